// File: doc/BRIEF.md
# Paged Program Counter Unit

This block holds the instruction address of a small microcontroller core. The address is 13 bits wide. Its lower eight bits behave as an ordinary register: software reads them and writes them. The five upper bits cannot be reached directly. They are taken from a separate five-bit page latch whenever the counter jumps somewhere other than the next instruction.

The way the upper bits are formed depends on the kind of load:

- **Low-byte write.** This includes an add to the low byte that performs a computed jump. The whole latch becomes bits 12:8.
- **Jump or call.** An 11-bit target field from the opcode fills bits 10:0, and only latch bits 4:3 fill bits 12:11.
- **Return.** The full popped value is used, and the latch is neither read nor changed.

The block offers the address of the following instruction as the value to push on a call or interrupt entry. Instruction decode, the ALU, the return-address stack and program memory all sit outside the block.

Top module: `pcu_top`

## Requirements
- R1: After reset, `pc_o` is 0x0000 and the page latch is 0x00, so a low-byte write that follows reset yields an upper field of zero.
- R2: With only `inc_en` asserted, `pc_o` becomes `pc_o`+1 modulo 2^13 at the next clock, so 0x1FFF wraps to 0x0000.
- R3: A low-byte write sets `pc_o` to {latch[4:0], `lo_wr_data`} at the next clock.
- R4: A jump or call sets `pc_o` to {latch[4:3], `tgt_addr`[10:0]} at the next clock.
- R5: A return sets `pc_o` to `ret_addr` at the next clock and leaves the page latch unchanged.
- R6: `push_en_o` is high exactly while `call_en` or `irq_en` is high, and `push_addr_o` always equals `pc_o`+1 modulo 2^13.
- R7: An interrupt strobe sets `pc_o` to the vector 0x004 at the next clock.
- R8: When several strobes are asserted together, the winner is chosen in this order, highest first: interrupt, jump/call, return, low-byte write, increment.
- R9: `pcl_o` always equals `pc_o`[7:0].
- R10: A low-byte write never carries into the upper field. Bits 12:8 come from the latch, whatever the previous upper bits were.
- R11: With no strobe asserted, `pc_o` holds its value.
- R12: A latch write takes effect one clock later. A load in the same cycle as a latch write uses the previous latch contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inc_en | input | 1 | Advance to the next sequential address |
| lo_wr_en | input | 1 | Write the low byte from the ALU result |
| lo_wr_data | input | 8 | ALU result for the low byte |
| jump_en | input | 1 | Jump strobe |
| call_en | input | 1 | Call strobe (also requests a push) |
| tgt_addr | input | 11 | Opcode target field |
| ret_en | input | 1 | Return strobe |
| ret_addr | input | 13 | Value popped from the stack |
| irq_en | input | 1 | Accepted interrupt (vector and push) |
| lat_wr_en | input | 1 | Page latch write strobe |
| lat_wr_data | input | 5 | Page latch write data |
| pc_o | output | 13 | Current program counter |
| pcl_o | output | 8 | Low-byte read value |
| push_addr_o | output | 13 | Return address to push |
| push_en_o | output | 1 | Push request |

## Verification
The bench builds the block with its default widths: a 13-bit counter, an 8-bit low byte and an 11-bit target field. It also uses the default interrupt vector of 0x004. With these values, the jump path can place the counter at 0x1FFE in one load, which brings the 13-bit wrap and the all-ones page field within two clocks. The five-bit latch lets the computed-jump checks set an upper field that differs from the counter's current upper bits. That difference is what separates a latch-sourced upper field from a carried one.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

    localparam int unsigned PCU_PC_W  = 13;
    localparam int unsigned PCU_LO_W  = 8;
    localparam int unsigned PCU_TGT_W = 11;
    localparam int unsigned PCU_VEC   = 4;

    // Load source chosen for the next counter value
    typedef enum logic [2:0] {
        SRC_HOLD = 3'd0,
        SRC_INC  = 3'd1,
        SRC_LOWR = 3'd2,
        SRC_RET  = 3'd3,
        SRC_JMP  = 3'd4,
        SRC_IRQ  = 3'd5
    } pc_src_e;

endpackage

// File: rtl/pcu_hilatch.sv
module pcu_hilatch #(
    parameter int unsigned LAT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [LAT_W-1:0] wr_data_i,
    output logic [LAT_W-1:0] lat_o
);

    logic [LAT_W-1:0] lat_d, lat_q;

    always_comb begin
        lat_d = lat_q;
        if (wr_en_i) begin
            lat_d = wr_data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_q <= '0;
        end else begin
            lat_q <= lat_d;
        end
    end

    assign lat_o = lat_q;

endmodule

// File: rtl/pcu_incr.sv
module pcu_incr #(
    parameter int unsigned W = 13
) (
    input  logic [W-1:0] a_i,
    output logic [W-1:0] sum_o
);

    // Modulo-2^W increment; the carry out is dropped on purpose
    always_comb begin
        sum_o = a_i + W'(1);
    end

endmodule

// File: rtl/pcu_srcsel.sv
module pcu_srcsel
    import pcu_pkg::*;
(
    input  logic    irq_i,
    input  logic    jump_i,
    input  logic    call_i,
    input  logic    ret_i,
    input  logic    lowr_i,
    input  logic    inc_i,
    output pc_src_e src_o
);

    // Fixed priority: interrupt, jump/call, return, low write, increment
    always_comb begin
        if (irq_i) begin
            src_o = SRC_IRQ;
        end else if (jump_i || call_i) begin
            src_o = SRC_JMP;
        end else if (ret_i) begin
            src_o = SRC_RET;
        end else if (lowr_i) begin
            src_o = SRC_LOWR;
        end else if (inc_i) begin
            src_o = SRC_INC;
        end else begin
            src_o = SRC_HOLD;
        end
    end

endmodule

// File: rtl/pcu_top.sv
module pcu_top
    import pcu_pkg::*;
#(
    parameter int unsigned PC_W     = PCU_PC_W,
    parameter int unsigned LO_W     = PCU_LO_W,
    parameter int unsigned TGT_W    = PCU_TGT_W,
    parameter int unsigned VEC_ADDR = PCU_VEC
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    inc_en,
    input  logic                    lo_wr_en,
    input  logic [LO_W-1:0]         lo_wr_data,
    input  logic                    jump_en,
    input  logic                    call_en,
    input  logic [TGT_W-1:0]        tgt_addr,
    input  logic                    ret_en,
    input  logic [PC_W-1:0]         ret_addr,
    input  logic                    irq_en,
    input  logic                    lat_wr_en,
    input  logic [PC_W-LO_W-1:0]    lat_wr_data,
    output logic [PC_W-1:0]         pc_o,
    output logic [LO_W-1:0]         pcl_o,
    output logic [PC_W-1:0]         push_addr_o,
    output logic                    push_en_o
);

    localparam int unsigned LAT_W    = PC_W - LO_W;
    localparam int unsigned PAGE_W   = PC_W - TGT_W;
    localparam int unsigned PAGE_LSB = TGT_W - LO_W;

    typedef struct packed {
        logic [PC_W-1:0] pc;
    } pcu_state_t;

    pcu_state_t       state_d, state_q;
    logic [LAT_W-1:0] latch_q;
    logic [PC_W-1:0]  pc_next_seq;
    logic [PC_W-1:0]  jmp_target;
    logic [PC_W-1:0]  lowr_target;
    pc_src_e          src;

    pcu_hilatch #(.LAT_W(LAT_W)) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (lat_wr_en),
        .wr_data_i (lat_wr_data),
        .lat_o     (latch_q)
    );

    pcu_incr #(.W(PC_W)) u_incr (
        .a_i   (state_q.pc),
        .sum_o (pc_next_seq)
    );

    pcu_srcsel u_sel (
        .irq_i  (irq_en),
        .jump_i (jump_en),
        .call_i (call_en),
        .ret_i  (ret_en),
        .lowr_i (lo_wr_en),
        .inc_i  (inc_en),
        .src_o  (src)
    );

    // Jump/call target: the upper page bits come from the matching latch bits
    generate
        if (PAGE_W > 0) begin : g_paged
            assign jmp_target = {latch_q[PAGE_LSB +: PAGE_W], tgt_addr};
        end else begin : g_flat
            assign jmp_target = tgt_addr[PC_W-1:0];
        end
    endgenerate

    // Low-byte write: the whole latch forms the upper field (no carry in)
    assign lowr_target = {latch_q, lo_wr_data};

    always_comb begin
        state_d = state_q;
        unique case (src)
            SRC_IRQ:  state_d.pc = PC_W'(VEC_ADDR);
            SRC_JMP:  state_d.pc = jmp_target;
            SRC_RET:  state_d.pc = ret_addr;
            SRC_LOWR: state_d.pc = lowr_target;
            SRC_INC:  state_d.pc = pc_next_seq;
            default:  state_d.pc = state_q.pc;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign pc_o        = state_q.pc;
    assign pcl_o       = state_q.pc[LO_W-1:0];
    assign push_addr_o = pc_next_seq;
    assign push_en_o   = call_en | irq_en;

endmodule

// File: rtl/pcu_chk.sv
module pcu_chk #(
    parameter int unsigned PC_W     = 13,
    parameter int unsigned LO_W     = 8,
    parameter int unsigned TGT_W    = 11,
    parameter int unsigned VEC_ADDR = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              inc_en,
    input logic              lo_wr_en,
    input logic [LO_W-1:0]   lo_wr_data,
    input logic              jump_en,
    input logic              call_en,
    input logic [TGT_W-1:0]  tgt_addr,
    input logic              ret_en,
    input logic [PC_W-1:0]   ret_addr,
    input logic              irq_en,
    input logic [PC_W-1:0]   pc_o
);

    logic jc;
    assign jc = jump_en | call_en;

    // R1: the first cycle out of reset sees a cleared counter
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> pc_o == '0);

    // R7
    a_r7_irq_vector: assert property (@(posedge clk) disable iff (!rst_n)
        irq_en |=> pc_o == PC_W'(VEC_ADDR));

    // R4
    a_r4_jump_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_en && jc) |=> pc_o[TGT_W-1:0] == $past(tgt_addr));

    // R5
    a_r5_ret_load: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_en && !jc && ret_en) |=> pc_o == $past(ret_addr));

    // R3
    a_r3_low_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_en && !jc && !ret_en && lo_wr_en) |=> pc_o[LO_W-1:0] == $past(lo_wr_data));

    // R2
    a_r2_increment: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_en && !jc && !ret_en && !lo_wr_en && inc_en) |=> pc_o == PC_W'($past(pc_o) + PC_W'(1)));

    // R11
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_en && !jc && !ret_en && !lo_wr_en && !inc_en) |=> $stable(pc_o));

endmodule

bind pcu_top pcu_chk #(
    .PC_W(PC_W), .LO_W(LO_W), .TGT_W(TGT_W), .VEC_ADDR(VEC_ADDR)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .inc_en     (inc_en),
    .lo_wr_en   (lo_wr_en),
    .lo_wr_data (lo_wr_data),
    .jump_en    (jump_en),
    .call_en    (call_en),
    .tgt_addr   (tgt_addr),
    .ret_en     (ret_en),
    .ret_addr   (ret_addr),
    .irq_en     (irq_en),
    .pc_o       (pc_o)
);

// File: tb/pcu_top_tb_top.sv
module pcu_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        inc_en, lo_wr_en, jump_en, call_en, ret_en, irq_en, lat_wr_en;
    logic [7:0]  lo_wr_data;
    logic [10:0] tgt_addr;
    logic [12:0] ret_addr;
    logic [4:0]  lat_wr_data;
    logic [12:0] pc_o, push_addr_o;
    logic [7:0]  pcl_o;
    logic        push_en_o;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    pcu_top dut_i (
        .clk(clk), .rst_n(rst_n), .inc_en(inc_en), .lo_wr_en(lo_wr_en),
        .lo_wr_data(lo_wr_data), .jump_en(jump_en), .call_en(call_en),
        .tgt_addr(tgt_addr), .ret_en(ret_en), .ret_addr(ret_addr),
        .irq_en(irq_en), .lat_wr_en(lat_wr_en), .lat_wr_data(lat_wr_data),
        .pc_o(pc_o), .pcl_o(pcl_o), .push_addr_o(push_addr_o), .push_en_o(push_en_o)
    );

    task automatic chk(input string tag, input logic [12:0] act, input logic [12:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%04h expected=0x%04h", tag, act, exp);
        end
    endtask

    task automatic idle();
        inc_en = 0; lo_wr_en = 0; jump_en = 0; call_en = 0; ret_en = 0;
        irq_en = 0; lat_wr_en = 0; lo_wr_data = '0; tgt_addr = '0;
        ret_addr = '0; lat_wr_data = '0;
    endtask

    // Inputs are driven after a falling edge; the result is sampled at the next falling edge
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        idle();
    endtask

    task automatic set_latch(input logic [4:0] v);
        lat_wr_en = 1; lat_wr_data = v; tick();
    endtask

    task automatic load_jump(input logic [4:0] lat, input logic [10:0] t);
        set_latch(lat);
        jump_en = 1; tgt_addr = t; tick();
    endtask

    task automatic t_reset();
        rst_n = 0; idle();
        @(negedge clk); @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 pc after reset", pc_o, 13'h0000);
        chk("R9 pcl after reset", {5'd0, pcl_o}, 13'h0000);
        chk("R6 no push at rest", {12'd0, push_en_o}, 13'h0000);
        lo_wr_en = 1; lo_wr_data = 8'h77; tick();
        chk("R1 latch cleared", pc_o, 13'h0077);
    endtask

    task automatic t_increment();
        load_jump(5'h18, 11'h7FE);
        chk("R4 jump to top page", pc_o, 13'h1FFE);
        inc_en = 1; tick();
        chk("R2 inc to 1FFF", pc_o, 13'h1FFF);
        chk("R6 push wraps", push_addr_o, 13'h0000);
        inc_en = 1; tick();
        chk("R2 wrap to 0", pc_o, 13'h0000);
    endtask

    task automatic t_hold();
        load_jump(5'h00, 11'h155);
        tick(); tick();
        chk("R11 hold", pc_o, 13'h0155);
    endtask

    task automatic t_lowrite();
        set_latch(5'h15);
        lo_wr_en = 1; lo_wr_data = 8'hA5; tick();
        chk("R3 low write", pc_o, 13'h15A5);
        chk("R9 pcl read", {5'd0, pcl_o}, 13'h00A5);
    endtask

    task automatic t_nocarry();
        set_latch(5'h03);
        lo_wr_en = 1; lo_wr_data = 8'hFF; tick();
        chk("R10 setup", pc_o, 13'h03FF);
        inc_en = 1; tick();
        chk("R2 carry on inc", pc_o, 13'h0400);
        lo_wr_en = 1; lo_wr_data = 8'h02; tick();
        chk("R10 no carry on low write", pc_o, 13'h0302);
    endtask

    task automatic t_jump_call();
        load_jump(5'h0B, 11'h7FF);
        chk("R4 jump page bits 01", pc_o, 13'h0FFF);
        set_latch(5'h07);
        call_en = 1; tgt_addr = 11'h123;
        #1;
        chk("R6 push en on call", {12'd0, push_en_o}, 13'h0001);
        chk("R6 push addr on call", push_addr_o, 13'h1000);
        tick();
        chk("R4 call ignores latch bits 2:0", pc_o, 13'h0123);
    endtask

    task automatic t_return();
        set_latch(5'h15);
        ret_en = 1; ret_addr = 13'h1ABC; tick();
        chk("R5 return load", pc_o, 13'h1ABC);
        lo_wr_en = 1; lo_wr_data = 8'h10; tick();
        chk("R5 latch unchanged", pc_o, 13'h1510);
    endtask

    task automatic t_irq();
        load_jump(5'h00, 11'h321);
        irq_en = 1;
        #1;
        chk("R6 push en on irq", {12'd0, push_en_o}, 13'h0001);
        chk("R6 push addr on irq", push_addr_o, 13'h0322);
        tick();
        chk("R7 irq vector", pc_o, 13'h0004);
    endtask

    task automatic t_priority();
        set_latch(5'h08);
        irq_en = 1; jump_en = 1; ret_en = 1; lo_wr_en = 1; inc_en = 1;
        tgt_addr = 11'h0AA; ret_addr = 13'h1111; lo_wr_data = 8'h55; tick();
        chk("R8 irq wins", pc_o, 13'h0004);
        call_en = 1; ret_en = 1; lo_wr_en = 1; inc_en = 1;
        tgt_addr = 11'h0AA; ret_addr = 13'h1111; lo_wr_data = 8'h55; tick();
        chk("R8 call beats return", pc_o, 13'h08AA);
        ret_en = 1; lo_wr_en = 1; inc_en = 1;
        ret_addr = 13'h1111; lo_wr_data = 8'h55; tick();
        chk("R8 return beats low write", pc_o, 13'h1111);
        lo_wr_en = 1; inc_en = 1; lo_wr_data = 8'h55; tick();
        chk("R8 low write beats inc", pc_o, 13'h0855);
    endtask

    task automatic t_latch_timing();
        set_latch(5'h00);
        lat_wr_en = 1; lat_wr_data = 5'h0A; lo_wr_en = 1; lo_wr_data = 8'h33; tick();
        chk("R12 same-cycle uses old latch", pc_o, 13'h0033);
        lo_wr_en = 1; lo_wr_data = 8'h44; tick();
        chk("R12 new latch next cycle", pc_o, 13'h0A44);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        idle();
        @(negedge clk);
        t_reset();
        t_increment();
        t_hold();
        t_lowrite();
        t_nocarry();
        t_jump_call();
        t_return();
        t_irq();
        t_priority();
        t_latch_timing();
        load_jump(5'h1F, 11'h7FF);
        t_reset();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule